// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block is the host-side controller that writes one page of a byte-wide NAND-style memory. A request names the target page, the starting column and the number of bytes. The bytes themselves arrive on a separate valid/ready stream. The block then drives the bus cycles in order: the load command, three address cycles, the data bytes and the confirm command. Command cycles raise the command-latch strobe and address cycles raise the address-latch strobe. Every bus cycle is clocked into the memory by a write strobe whose low and high phases last a programmable number of clocks.

Once the confirm command has gone out, the block finds out when the memory is finished. The request selects one of two methods. In the first, the block waits for the ready/busy line to go high, then issues the status command and reads one status byte. In the second, it issues the status command at once and keeps reading status until the ready bit is set. In both cases the outcome comes from the pass/fail bit of the last status byte read. A busy timeout ends the wait with an error.

Some requests are refused before any bus cycle is driven: those asking for zero bytes, those asking for more bytes than a page holds, and those that would be an eleventh partial program of a page since the last erase. Every request ends with a one-cycle done pulse carrying a result code.

Top module: `nand_prog_seq`

## Requirements
- R1: An accepted request produces these latched bus cycles in this order: command 0x80 (command-latch high), three address cycles (address-latch high), exactly `req_len` data cycles (both latches low), command 0x10, and then command 0x70. Command-latch and address-latch are never high together.
- R2: The three address cycles carry, in this order, `req_col`, `req_page[7:0]` and `req_page[15:8]`. The data cycles carry the stream bytes in the order they were accepted.
- R3: Every write strobe stays low for exactly `WE_CLKS` clocks. The bus byte, command-latch and address-latch do not change while the strobe is low.
- R4: A request with `req_len` greater than 528 is refused with result 3 on the next cycle, and no bus cycle is driven. A request with `req_len` equal to 528 is carried out.
- R5: A request with `req_len` equal to 0 is refused with result 4 on the next cycle. No bus cycle is driven, so no confirm command is issued.
- R6: Each accepted request increments a partial-program counter for its page. The page is identified by the low `TRK_W` bits of the page number. A request to a page whose counter has reached 10 is refused with result 5. A pulse on `erase_clr` resets all counters to zero.
- R7: In ready/busy mode (`req_poll`=0), the status command is issued only after `nf_rb` has been seen high, and exactly one status byte is read. The bus output enable is low whenever the read strobe is low.
- R8: In polling mode (`req_poll`=1), the status command follows the confirm directly. Status bytes are read again and again until one has bit 6 set. The write and read strobes are never low at the same time.
- R9: The result comes from bit 0 of the final status byte. If bit 0 is 0, the result is 0 (pass). If bit 0 is 1, the result is 1 (fail).
- R10: If the memory stays busy for `TMO_CLKS` clocks after the confirm, the block ends with result 2 and issues no status command.
- R11: `done` is a single-cycle pulse, given exactly once per request. `req_ready` is low from the acceptance of a carried-out request until its done pulse.
- R12: During and after reset, `req_ready` is 1, `done` is 0, both strobes are high and both latch signals are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_page | input | 16 | Target page row |
| req_col | input | 8 | Start column |
| req_len | input | LEN_W | Number of data bytes |
| req_poll | input | 1 | 1: poll status bit 6; 0: wait for ready/busy |
| dat_valid | input | 1 | Stream byte present |
| dat_ready | output | 1 | Stream byte taken when valid |
| dat_byte | input | 8 | Stream byte |
| erase_clr | input | 1 | Clear all partial-program counters |
| nf_io_out | output | 8 | Bus byte driven to the memory |
| nf_io_oe | output | 1 | Bus drive enable |
| nf_cle | output | 1 | Command-latch strobe |
| nf_ale | output | 1 | Address-latch strobe |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_in | input | 8 | Bus byte from the memory |
| nf_rb | input | 1 | Ready (1) / busy (0) |
| done | output | 1 | Result pulse |
| result | output | 3 | 0 pass, 1 fail, 2 timeout, 3 too long, 4 empty, 5 limit |

## Verification
Refusals are registered at the accepting edge, so the bench expects `done` and the code at the very next sample. It also expects `done` to be low again one sample after that. A carried-out request takes one bus cycle of 2·WE_CLKS+1 clocks for each command, address and data byte, plus the busy time and the status reads. For these, the bench waits for `done` with a bounded count and then compares the recorded bus log, the number of status reads and the measured strobe widths against the values computed from the request. For a timeout, the bench measures the cycle count from acceptance to `done`. It requires that count to fall between `TMO_CLKS` and `TMO_CLKS` plus the time taken by the bus cycles.

// File: rtl/nand_prog_seq.sv
module nand_prog_seq #(
  parameter int WE_CLKS   = 2,
  parameter int TMO_CLKS  = 4000,
  parameter int MAX_BYTES = 528,
  parameter int MAX_PART  = 10,
  parameter int TRK_W     = 5,
  parameter int LEN_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_page,
  input  logic [7:0]       req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_poll,
  input  logic             dat_valid,
  output logic             dat_ready,
  input  logic [7:0]       dat_byte,
  input  logic             erase_clr,
  output logic [7:0]       nf_io_out,
  output logic             nf_io_oe,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  input  logic [7:0]       nf_io_in,
  input  logic             nf_rb,
  output logic             done,
  output logic [2:0]       result
);
  localparam int PH_W  = $clog2(2*WE_CLKS+1);
  localparam int TMO_W = $clog2(TMO_CLKS+1);
  localparam int CNT_W = $clog2(MAX_PART+1);
  localparam int TRK_N = 1 << TRK_W;

  typedef enum logic [2:0] {IDLE, C80, ADR, DAT, C10, WRB, C70, RST} st_t;

  st_t              st;
  logic [PH_W-1:0]  ph;
  logic [1:0]       aidx;
  logic [LEN_W-1:0] left;
  logic [15:0]      page;
  logic [7:0]       col, dbyte;
  logic             poll, st_rdy, st_fail;
  logic [TMO_W-1:0] tmo;
  logic [CNT_W-1:0] cnt [TRK_N];
  logic             unused_io;

  wire [TRK_W-1:0] ridx = req_page[TRK_W-1:0];
  wire last_ph = ph == PH_W'(2*WE_CLKS);
  wire low     = ph != '0 && ph <= PH_W'(WE_CLKS);
  wire hold    = st == DAT && ph == '0 && !dat_valid;
  wire wr_st   = st inside {C80, ADR, DAT, C10, C70};
  wire tmo_hit = tmo == TMO_W'(TMO_CLKS-1);
  wire take    = req_valid && st == IDLE && req_len != '0 &&
                 req_len <= LEN_W'(MAX_BYTES) && cnt[ridx] < CNT_W'(MAX_PART);

  assign req_ready = st == IDLE;
  assign dat_ready = st == DAT && ph == '0;
  assign nf_we_n   = !(wr_st && low);
  assign nf_re_n   = !(st == RST && low);
  assign nf_io_oe  = wr_st;
  assign nf_cle    = st inside {C80, C10, C70};
  assign nf_ale    = st == ADR;
  assign unused_io = ^nf_io_in[5:1] ^ nf_io_in[7];

  always_comb begin
    case (st)
      C80:     nf_io_out = 8'h80;
      ADR:     nf_io_out = aidx == 2'd0 ? col : aidx == 2'd1 ? page[7:0] : page[15:8];
      DAT:     nf_io_out = dbyte;
      C10:     nf_io_out = 8'h10;
      C70:     nf_io_out = 8'h70;
      default: nf_io_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TRK_N; i++) cnt[i] <= '0;
    end else if (erase_clr) begin
      for (int i = 0; i < TRK_N; i++) cnt[i] <= '0;
    end else if (take) begin
      cnt[ridx] <= cnt[ridx] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; ph <= '0; aidx <= '0; left <= '0; page <= '0; col <= '0;
      dbyte <= '0; poll <= 1'b0; st_rdy <= 1'b0; st_fail <= 1'b0; tmo <= '0;
      done <= 1'b0; result <= '0;
    end else begin
      done <= 1'b0;
      if (st == IDLE || st == WRB || hold || last_ph) ph <= '0;
      else ph <= ph + 1'b1;
      case (st)
        IDLE: if (req_valid) begin
          if (take) begin
            st <= C80; page <= req_page; col <= req_col; left <= req_len; poll <= req_poll;
          end else begin
            done   <= 1'b1;
            result <= req_len > LEN_W'(MAX_BYTES) ? 3'd3 : req_len == '0 ? 3'd4 : 3'd5;
          end
        end
        C80: if (last_ph) begin st <= ADR; aidx <= '0; end
        ADR: if (last_ph) begin
          aidx <= aidx + 1'b1;
          if (aidx == 2'd2) st <= DAT;
        end
        DAT: begin
          if (dat_ready && dat_valid) dbyte <= dat_byte;
          if (last_ph) begin
            left <= left - 1'b1;
            if (left == LEN_W'(1)) st <= C10;
          end
        end
        C10: if (last_ph) begin tmo <= '0; st <= poll ? C70 : WRB; end
        WRB: begin
          tmo <= tmo + 1'b1;
          if (nf_rb) begin st <= C70; tmo <= '0; end
          else if (tmo_hit) begin st <= IDLE; done <= 1'b1; result <= 3'd2; end
        end
        C70: begin
          tmo <= tmo + 1'b1;
          if (last_ph) st <= RST;
        end
        RST: begin
          tmo <= tmo + 1'b1;
          if (ph == PH_W'(WE_CLKS)) begin st_rdy <= nf_io_in[6]; st_fail <= nf_io_in[0]; end
          if (last_ph && (!poll || st_rdy)) begin
            st <= IDLE; done <= 1'b1; result <= {2'b00, st_fail};
          end else if (poll && tmo_hit) begin
            st <= IDLE; done <= 1'b1; result <= 3'd2;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_prog_seq_chk.sv
module nand_prog_seq_chk #(
  parameter int LEN_W     = 10,
  parameter int MAX_BYTES = 528
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic [7:0]       nf_io_out,
  input logic             nf_io_oe,
  input logic             nf_cle,
  input logic             nf_ale,
  input logic             nf_we_n,
  input logic             nf_re_n,
  input logic             done,
  input logic [2:0]       result
);
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale)); // R1
  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && $past(!nf_we_n)) |-> ($stable(nf_io_out) && $stable(nf_cle) && $stable(nf_ale))); // R3
  AST_LONG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len > LEN_W'(MAX_BYTES)) |=> (done && result == 3'd3)); // R4
  AST_EMPTY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (done && result == 3'd4 && nf_we_n)); // R5
  AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n) !nf_re_n |-> !nf_io_oe); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(!nf_we_n && !nf_re_n)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
endmodule

bind nand_prog_seq nand_prog_seq_chk #(.LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
  .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_cle(nf_cle), .nf_ale(nf_ale),
  .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .done(done), .result(result)
);

// File: tb/nand_prog_seq_bench.sv
`timescale 1ns/1ps
module nand_prog_seq_bench;
  localparam int W   = 2;
  localparam int TMO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_poll = 1'b0, dat_valid = 1'b1, erase_clr = 1'b0;
  logic [15:0] req_page = '0;
  logic [7:0]  req_col = '0, dat_byte, seed = '0;
  logic [9:0]  req_len = '0;
  logic req_ready, dat_ready, nf_io_oe, nf_cle, nf_ale, nf_we_n, nf_re_n, done;
  logic [7:0] nf_io_out, nf_io_in;
  logic [2:0] result;
  logic rb = 1'b1, fbit = 1'b0, hang = 1'b0;

  int errors = 0, checks = 0;
  int nlog = 0, rd_cnt = 0, didx = 0, strobe_bad = 0, lowrun = 0, busy_cnt = 0, busy_len = 0;
  logic [9:0] blog [0:599];
  logic we_q = 1'b1, re_q = 1'b1, cle_q = 1'b0, ale_q = 1'b0, take_q = 1'b0;
  logic [7:0] io_q = '0;

  always #2 clk = ~clk;

  assign dat_byte = seed + 8'(didx);
  assign nf_io_in = {1'b1, rb, 5'b0, fbit};

  nand_prog_seq #(.WE_CLKS(W), .TMO_CLKS(TMO)) u_nand_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_col(req_col), .req_len(req_len), .req_poll(req_poll),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte), .erase_clr(erase_clr),
    .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_in(nf_io_in), .nf_rb(nf_rb_w),
    .done(done), .result(result));
  wire nf_rb_w = rb;

  always @(negedge clk) begin
    if (take_q) didx++;
    take_q = dat_ready && dat_valid;
    if (!we_q && nf_we_n) begin
      if (nlog < 600) blog[nlog] = {cle_q, ale_q, io_q};
      nlog++;
      if (cle_q && io_q == 8'h10) begin busy_cnt = busy_len; rb = 1'b0; end
    end else if (!rb && !hang) begin
      if (busy_cnt == 0) rb = 1'b1; else busy_cnt--;
    end
    if (!nf_we_n) lowrun++;
    else begin
      if (!we_q && lowrun != W) strobe_bad++;
      lowrun = 0;
    end
    if (!re_q && nf_re_n) rd_cnt++;
    we_q = nf_we_n; re_q = nf_re_n; cle_q = nf_cle; ale_q = nf_ale; io_q = nf_io_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] pg, input logic [7:0] col, input logic [9:0] len, input bit poll);
    @(negedge clk);
    nlog = 0; rd_cnt = 0; didx = 0; strobe_bad = 0;
    seed = pg[7:0] ^ 8'h5a;
    req_page = pg; req_col = col; req_len = len; req_poll = poll; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
  endtask

  task automatic after_done(input string req);
    @(negedge clk);
    chk(done == 1'b0, req, done, 0);
    chk(req_ready == 1'b1, req, req_ready, 1);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1 && done == 1'b0, "R12 idle", {req_ready, done}, 2);
    chk(nf_we_n && nf_re_n && !nf_cle && !nf_ale, "R12 bus", {nf_we_n, nf_re_n, nf_cle, nf_ale}, 12);
  endtask

  task automatic t_prog(input logic [15:0] pg, input logic [7:0] col, input int len,
                        input bit poll, input int busy, input bit fb, input int exp, input string tag);
    int cyc;
    bit ok;
    busy_len = busy; fbit = fb;
    issue(pg, col, 10'(len), poll);
    chk(req_ready == 1'b0, {tag, " R11 busy"}, req_ready, 0);
    wait_done(cyc);
    chk(done && result == 3'(exp), {tag, " R9 result"}, result, exp);
    after_done({tag, " R11 pulse"});
    chk(nlog == len + 6, {tag, " R1 cycles"}, nlog, len + 6);
    ok = blog[0] == {2'b10, 8'h80} && blog[len+4] == {2'b10, 8'h10} && blog[len+5] == {2'b10, 8'h70};
    chk(ok, {tag, " R1 commands"}, blog[len+4], {2'b10, 8'h10});
    ok = blog[1] == {2'b01, col} && blog[2] == {2'b01, pg[7:0]} && blog[3] == {2'b01, pg[15:8]};
    chk(ok, {tag, " R2 address"}, blog[2], {2'b01, pg[7:0]});
    ok = 1'b1;
    for (int i = 0; i < len; i++) if (blog[4+i] != {2'b00, 8'(seed + 8'(i))}) ok = 1'b0;
    chk(ok, {tag, " R2 data"}, 0, 0);
    chk(strobe_bad == 0, {tag, " R3 strobe width"}, strobe_bad, 0);
    if (poll) chk(busy > 0 ? rd_cnt > 1 : rd_cnt >= 1, {tag, " R8 status polls"}, rd_cnt, 2);
    else chk(rd_cnt == 1, {tag, " R7 single status read"}, rd_cnt, 1);
  endtask

  task automatic t_refuse(input logic [15:0] pg, input logic [9:0] len, input int exp, input string tag);
    int cyc;
    issue(pg, 8'h00, len, 1'b0);
    chk(done && result == 3'(exp), {tag, " refused next cycle"}, result, exp);
    after_done({tag, " R11 pulse"});
    repeat (8) @(negedge clk);
    chk(nlog == 0, {tag, " no bus cycles"}, nlog, 0);
    wait_done(cyc);
  endtask

  task automatic t_limit;
    for (int i = 0; i < 10; i++) t_prog(16'h0207, 8'h00, 1, 1'b0, 3, 1'b0, 0, "R6 within limit");
    t_refuse(16'h0207, 10'd1, 5, "R6 eleventh");
    @(negedge clk); erase_clr = 1'b1;
    @(negedge clk); erase_clr = 1'b0;
    t_prog(16'h0207, 8'h00, 1, 1'b0, 3, 1'b0, 0, "R6 after erase");
  endtask

  task automatic t_timeout;
    int cyc, lim;
    hang = 1'b1; busy_len = 0; fbit = 1'b0;
    issue(16'h0042, 8'h01, 10'd4, 1'b0);
    wait_done(cyc);
    lim = TMO + 9 * (2*W + 1) + 4;
    chk(done && result == 3'd2, "R10 timeout code", result, 2);
    chk(cyc >= TMO && cyc <= lim, "R10 timeout delay", cyc, TMO);
    after_done("R10 R11 pulse");
    chk(nlog == 9 && rd_cnt == 0, "R10 no status command", nlog, 9);
    hang = 1'b0; rb = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog(16'hA531, 8'h10, 6, 1'b0, 40, 1'b0, 0, "R7 busy-line pass");
    t_prog(16'h1C02, 8'h00, 5, 1'b1, 60, 1'b0, 0, "R8 polled pass");
    t_prog(16'h3303, 8'hF0, 3, 1'b0, 20, 1'b1, 1, "R9 busy-line fail");
    t_prog(16'h7E04, 8'h22, 2, 1'b1, 30, 1'b1, 1, "R9 polled fail");
    t_prog(16'h0105, 8'h00, 528, 1'b0, 10, 1'b0, 0, "R4 full page");
    t_refuse(16'h0106, 10'd529, 3, "R4 oversize");
    t_refuse(16'h0108, 10'd0, 4, "R5 empty");
    t_limit();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule